// File: doc/BRIEF.md
# Sticky-Enable 64-bit Cycle Counter

This block keeps a 64-bit count of clock cycles and makes it visible to software as two 32-bit registers on a small register bus. Both registers are read-only. A write strobe aimed at the low-half address starts the count. The bus carries no write data, because no written value would ever be used. Once the count is running, no bus access stops it. Only reset or the power-down input stops it.

A read of the low half also captures the high half into a shadow register. A later read of the high-half address returns that shadow, so software gets one consistent 64-bit value from two 32-bit reads, even when a carry crosses between the halves. Read data is registered and appears one cycle after the read strobe. The output holds its value until the next read.

The half width is a parameter. A narrow instance therefore shows the carry and wrap behaviour in a few hundred cycles.

Top module: `cycle_counter64`

## Requirements
- R1: While reset is asserted and after it is released, the count is 0, counting is off and `bus_rdata` is 0.
- R2: While counting is on and `pwr_down` is low, the count grows by exactly one on every clock edge.
- R3: A cycle with `bus_wr`=1 and `bus_addr`=0 (the low half) turns counting on. The count first grows on the edge after that write.
- R4: Once counting is on, no combination of bus reads or writes turns it off.
- R5: A write with `bus_addr`=1 (the high half) has no effect. It does not start counting and does not change the count.
- R6: While `pwr_down`=1 the count holds its value and counting is switched off. After `pwr_down` falls, the count stays frozen until another low-half write.
- R7: A read with `bus_addr`=0 returns bits [HALF_W-1:0] of the count as it stood before that edge. On the same edge it copies bits [2*HALF_W-1:HALF_W] into the shadow.
- R8: A read with `bus_addr`=1 returns the shadow. The live high half is not used, so a low read followed by a high read gives a consistent pair.
- R9: The count wraps from all ones to 0 and keeps running. No flag is raised.
- R10: `bus_rdata` changes only on the edge after a read strobe. In all other cycles it keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Full power-down: halts the count and clears the enable |
| bus_wr | input | 1 | Write strobe (only a low-half write has an effect) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Register select: 0 = low half, 1 = high half |
| bus_rdata | output | HALF_W | Registered read data, valid one cycle after `bus_rd` |

## Verification
The count is driven through several sequences: reads before any enable, a high-half write alone, a low-half write followed by repeated low writes, idle gaps of different lengths, and power-down pulses. These separate an enable that is sticky from one that toggles, and a count that starts too early from one that starts too late. Pairs of low and high reads with long gaps between them show whether the high read uses the shadow or the live value. A narrow instance takes the count across a half-to-half carry and through a full wrap, which shows whether the halves are split correctly and whether wrap is handled.

// File: rtl/cycle_counter64.sv
module cycle_counter64 #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  output logic [HALF_W-1:0] bus_rdata
);
  localparam int CNT_W = 2 * HALF_W;

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [HALF_W-1:0] shadow;

  wire wr_lo = bus_wr & ~bus_addr;
  wire rd_lo = bus_rd & ~bus_addr;
  wire step  = run & ~pwr_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= ~pwr_down & (run | wr_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow <= '0;
    else if (rd_lo) shadow <= cnt[CNT_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_addr ? shadow : cnt[HALF_W-1:0];
  end
endmodule

module cycle_counter64_chk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_addr,
  input logic [HALF_W-1:0] bus_rdata,
  input logic              run,
  input logic [2*HALF_W-1:0] cnt,
  input logic [HALF_W-1:0] shadow
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pwr_down) |=> cnt == $past(cnt) + ONE);

  // R6
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (cnt == $past(cnt)) && !run);

  // R3
  lo_write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && !pwr_down) |=> run);

  // R4
  sticky_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pwr_down) |=> run);

  // R5
  no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(bus_wr && !bus_addr)) |=> !run);

  // R7
  lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr) |=> (bus_rdata == $past(cnt[HALF_W-1:0]))
                              && (shadow == $past(cnt[CNT_W-1:HALF_W])));

  // R8
  hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr) |=> bus_rdata == $past(shadow));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind cycle_counter64 cycle_counter64_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .run(run), .cnt(cnt), .shadow(shadow)
);

// File: tb/cycle_counter64_tb.sv
module cycle_counter64_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic bus_addr = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  s_rdata;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cycle_counter64 #(.HALF_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(rdata));

  cycle_counter64 #(.HALF_W(4)) u_small (
    .clk(clk), .rst_n(s_rst_n), .pwr_down(pwr_down), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(s_rdata));

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        addr;
    logic        chk;
    logic [7:0]  idle;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [0:10] = '{
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 32'd0},   // R1 no count before enable
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 32'd0},   // R5 high write
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 32'd0},   // R5 still zero
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd4, 32'd0},   // R3 low write
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 32'd4},   // R3 count 4
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd0, 32'd0},   // R8 shadow high
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 32'd0},   // R4 second low write
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 32'd9},   // R4 still running
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd0, 32'd0},   // R8
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd5, 32'd0},   // R10 no read, held
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 32'd17}   // R2 steady count
  };
  string vtag [0:10] = '{"R1", "R5", "R5", "R3", "R3", "R8", "R4", "R4", "R8", "R10", "R2"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic rd, input logic addr);
    bus_wr = wr; bus_rd = rd; bus_addr = addr;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1", rdata, 32'd0);
    check("R1", {28'd0, s_rdata}, 32'd0);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < 11; i++) begin
      do_op(VEC[i].wr, VEC[i].rd, VEC[i].addr);
      if (VEC[i].chk) check(vtag[i], rdata, VEC[i].exp);
      idle(int'(VEC[i].idle));
    end

    // R6 power-down halts, keeps count 18, clears enable
    pwr_down = 1'b1;
    idle(10);
    pwr_down = 1'b0;
    idle(3);
    do_op(1'b0, 1'b1, 1'b0);
    check("R6", rdata, 32'd18);
    do_op(1'b1, 1'b0, 1'b0);
    idle(2);
    do_op(1'b0, 1'b1, 1'b0);
    check("R6", rdata, 32'd20);

    // R1 reset mid-run
    rst_n = 1'b0;
    idle(2);
    check("R1", rdata, 32'd0);
    rst_n = 1'b1;
    idle(3);
    do_op(1'b0, 1'b1, 1'b0);
    check("R1", rdata, 32'd0);
    do_op(1'b0, 1'b1, 1'b1);
    check("R1", rdata, 32'd0);

    // narrow instance: carry, shadow consistency, wrap
    rst_n = 1'b0;
    s_rst_n = 1'b1;
    idle(1);
    do_op(1'b1, 1'b0, 1'b0);
    idle(17);
    do_op(1'b0, 1'b1, 1'b0);
    check("R7", {28'd0, s_rdata}, 32'h1);
    idle(40);
    do_op(1'b0, 1'b1, 1'b1);
    check("R7", {28'd0, s_rdata}, 32'h1);
    idle(196);
    do_op(1'b0, 1'b1, 1'b0);
    check("R9", {28'd0, s_rdata}, 32'hF);
    do_op(1'b0, 1'b1, 1'b1);
    check("R9", {28'd0, s_rdata}, 32'hF);
    do_op(1'b0, 1'b1, 1'b0);
    check("R9", {28'd0, s_rdata}, 32'h1);
    do_op(1'b0, 1'b1, 1'b1);
    check("R9", {28'd0, s_rdata}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule